// File: doc/BRIEF.md
# Coherent DMA Tracker Sequencer

This block sits between an I/O hub's inbound DMA queues and a coherent home agent. It accepts DMA requests that span one or more 64-byte cache lines. It splits each request into line requests and runs every line through a small pool of tracker entries. A read takes one home round trip: a read request goes out and the tracker frees when the data returns.

A write takes two round trips. An ownership request goes out as soon as a tracker and the line are free, without waiting for older writes, so several ownership requests can be outstanding at once. The grant carries no data. The posted-queue logic outside the block presents the tag of the write that is now at the head of posted order. When that write's tracker holds ownership, the block issues the writeback, which also gives up ownership, and pops the posted queue. If a snoop-invalidate took the line away in the meantime, the head write re-requests ownership instead. A write's tracker frees only on the home agent's completion for the writeback.

Tracker states: IDLE, RD_PEND (read outstanding), OWN_PEND (ownership outstanding, or lost and awaiting re-request), OWNED, WB_PEND. Transitions:
- IDLE to RD_PEND on a read allocation.
- IDLE to OWN_PEND on a write allocation.
- RD_PEND to IDLE on DATA.
- OWN_PEND to OWNED on GRANT.
- OWNED to OWN_PEND on a snoop-invalidate (the entry is marked lost).
- OWNED to WB_PEND when the writeback issues.
- WB_PEND to IDLE on CMP.
- The lost mark clears when the ownership re-request issues.

The splitter has two states: SP_IDLE, which accepts a request, and SP_EMIT, which emits lines.

Top module: `dmatrk_seq`

## Requirements
- R1: A request with byte address A and N lines, accepted when req_valid and req_ready are both high at a clock edge, yields exactly N new line requests with line addresses A[31:6], A[31:6]+1, and so on, in that order. Bits A[5:0] are ignored. N = 0 yields nothing. req_ready is high exactly when no accepted lines remain to be issued.
- R2: A read line issues hreq_op = 0 (RD) with the allocated tag. That tracker frees on hrsp_op = 0 (DATA) for its tag.
- R3: A write line issues hreq_op = 1 (RFO) at allocation, without waiting for earlier writes, so multiple ownership requests can be outstanding together.
- R4: hrsp_op = 1 (GRANT) makes the tracker OWNED. A writeback, hreq_op = 2 (WB), with pq_pop high issues in the cycle where pq_head_valid is high and pq_head_tag names an OWNED tracker, and at no other time.
- R5: snp_inv_valid for an OWNED tag marks the line lost. When that tag is at the posted head, the block issues RFO for it again in place of a writeback, with no pop. No WB issues for a tag in the cycle it is snooped.
- R6: A written line's tracker stays busy through WB_PEND and frees only on hrsp_op = 2 (CMP) for its tag.
- R7: New lines take the lowest-numbered IDLE tracker; the tag is the tracker index. With no IDLE tracker the line is held, not dropped, and no more than 8 trackers are busy.
- R8: A line whose address equals that of any busy tracker is not issued until that tracker frees.
- R9: There is one home request port. A posted-head action (WB or re-RFO) takes it ahead of a waiting new line. Otherwise a new line with a free tracker and no conflict issues in the same cycle it is presented.
- R10: After reset, req_ready is high, hreq_valid is low and pq_pop is low.
- R11: A response whose op does not match the state of the addressed tracker (for example CMP or GRANT to a read) leaves that tracker unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Splitter idle, request accepted this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of first line |
| req_lines | input | 4 | Number of lines |
| hreq_valid | output | 1 | Home request issued this cycle |
| hreq_op | output | 2 | 0 RD, 1 RFO, 2 WB |
| hreq_tag | output | 3 | Tracker tag |
| hreq_line | output | 26 | Line address |
| hrsp_valid | input | 1 | Home response present |
| hrsp_op | input | 2 | 0 DATA, 1 GRANT, 2 CMP |
| hrsp_tag | input | 3 | Tag of response |
| snp_inv_valid | input | 1 | Ownership lost on a line |
| snp_inv_tag | input | 3 | Tag that lost ownership |
| pq_head_valid | input | 1 | A write is at posted head |
| pq_head_tag | input | 3 | Tag of that write |
| pq_pop | output | 1 | Head write committed |

## Verification
A corrupted tracker state surfaces on the home port in the very cycle it matters:
- A tracker stuck busy blocks its line or changes the lowest free tag on the next allocation.
- A tracker freed early lets a conflicting line through at once.
- A missed lost mark shows as a WB where a re-RFO was due as soon as that tag reaches the posted head.

Every cycle the bench predicts the exact home request and pop from its own tracker table, so any divergence is reported within one cycle of where it first becomes visible.

// File: rtl/dmatrk_pkg.sv
package dmatrk_pkg;
    typedef enum logic [2:0] {
        TS_IDLE,
        TS_RD_PEND,
        TS_OWN_PEND,
        TS_OWNED,
        TS_WB_PEND
    } trk_state_t;

    typedef enum logic {
        SP_IDLE,
        SP_EMIT
    } split_state_t;

    localparam logic [1:0] OP_RD  = 2'd0;
    localparam logic [1:0] OP_RFO = 2'd1;
    localparam logic [1:0] OP_WB  = 2'd2;

    localparam logic [1:0] RSP_DATA  = 2'd0;
    localparam logic [1:0] RSP_GRANT = 2'd1;
    localparam logic [1:0] RSP_CMP   = 2'd2;
endpackage

// File: rtl/dmatrk_splitter.sv
module dmatrk_splitter
    import dmatrk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int LEN_W  = 4,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_lines,
    output logic              req_ready,
    output logic              line_valid,
    output logic              line_wr,
    output logic [LINE_W-1:0] line_addr,
    input  logic              line_take
);
    split_state_t      sp_q;
    logic [LINE_W-1:0] cur_q;
    logic [LEN_W-1:0]  rem_q;
    logic              wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= SP_IDLE;
            cur_q <= '0;
            rem_q <= '0;
            wr_q  <= 1'b0;
        end else begin
            unique case (sp_q)
                SP_IDLE: begin
                    if (req_valid && req_lines != '0) begin
                        cur_q <= req_addr[ADDR_W-1:OFF_W];
                        rem_q <= req_lines;
                        wr_q  <= req_wr;
                        sp_q  <= SP_EMIT;
                    end
                end
                SP_EMIT: begin
                    if (line_take) begin
                        cur_q <= cur_q + LINE_W'(1);
                        rem_q <= rem_q - LEN_W'(1);
                        if (rem_q == LEN_W'(1)) sp_q <= SP_IDLE;
                    end
                end
                default: sp_q <= SP_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready  = (sp_q == SP_IDLE);
        line_valid = (sp_q == SP_EMIT);
        line_wr    = wr_q;
        line_addr  = cur_q;
    end

    AST_TAKE_HAS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        line_take |-> line_valid); // R1
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_take && rem_q > LEN_W'(1)) |=> (line_valid && line_addr == $past(line_addr) + LINE_W'(1))); // R1
endmodule

// File: rtl/dmatrk_entry.sv
module dmatrk_entry
    import dmatrk_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic              alloc_wr,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic              rsp_data,
    input  logic              rsp_grant,
    input  logic              rsp_cmp,
    input  logic              snp_inv,
    input  logic              wb_go,
    input  logic              rerfo_go,
    output trk_state_t        state,
    output logic [LINE_W-1:0] line,
    output logic              lost
);
    trk_state_t        st_q, st_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic              lost_q, lost_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= TS_IDLE;
            line_q <= '0;
            lost_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            line_q <= line_d;
            lost_q <= lost_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        line_d = line_q;
        lost_d = lost_q;
        unique case (st_q)
            TS_IDLE: begin
                if (alloc) begin
                    st_d   = alloc_wr ? TS_OWN_PEND : TS_RD_PEND;
                    line_d = alloc_line;
                    lost_d = 1'b0;
                end
            end
            TS_RD_PEND: begin
                if (rsp_data) st_d = TS_IDLE;
            end
            TS_OWN_PEND: begin
                if (rerfo_go)                 lost_d = 1'b0;
                else if (rsp_grant && !lost_q) st_d  = TS_OWNED;
            end
            TS_OWNED: begin
                if (snp_inv) begin
                    st_d   = TS_OWN_PEND;
                    lost_d = 1'b1;
                end else if (wb_go) begin
                    st_d = TS_WB_PEND;
                end
            end
            TS_WB_PEND: begin
                if (rsp_cmp) st_d = TS_IDLE;
            end
            default: st_d = TS_IDLE;
        endcase
    end

    always_comb begin
        state = st_q;
        line  = line_q;
        lost  = lost_q;
    end

    AST_ALLOC_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> st_q == TS_IDLE); // R7
    AST_WB_ONLY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        wb_go |-> (st_q == TS_OWNED && !snp_inv)); // R4
    AST_LOST_IN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        lost_q |-> st_q == TS_OWN_PEND); // R5
    AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_RD_PEND && rsp_data) |=> st_q == TS_IDLE); // R2
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_WB_PEND && !rsp_cmp) |=> st_q == TS_WB_PEND); // R6
endmodule

// File: rtl/dmatrk_seq.sv
module dmatrk_seq
    import dmatrk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int NTRK       = 8,
    parameter int LEN_W      = 4,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int TAG_W  = $clog2(NTRK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_lines,
    output logic              hreq_valid,
    output logic [1:0]        hreq_op,
    output logic [TAG_W-1:0]  hreq_tag,
    output logic [LINE_W-1:0] hreq_line,
    input  logic              hrsp_valid,
    input  logic [1:0]        hrsp_op,
    input  logic [TAG_W-1:0]  hrsp_tag,
    input  logic              snp_inv_valid,
    input  logic [TAG_W-1:0]  snp_inv_tag,
    input  logic              pq_head_valid,
    input  logic [TAG_W-1:0]  pq_head_tag,
    output logic              pq_pop
);
    logic              sp_valid, sp_wr, sp_take;
    logic [LINE_W-1:0] sp_line;

    dmatrk_splitter #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_split (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_wr(req_wr), .req_addr(req_addr),
        .req_lines(req_lines), .req_ready(req_ready),
        .line_valid(sp_valid), .line_wr(sp_wr), .line_addr(sp_line),
        .line_take(sp_take)
    );

    trk_state_t        st   [NTRK];
    logic [LINE_W-1:0] tline[NTRK];
    logic [NTRK-1:0]   tlost;
    logic [NTRK-1:0]   alloc_vec, wb_vec, rerfo_vec;

    logic             free_any, conflict, head_wb, head_rerfo, new_go;
    logic [TAG_W-1:0] free_tag;

    genvar gi;
    generate
        for (gi = 0; gi < NTRK; gi++) begin : g_trk
            logic hit;
            assign hit = hrsp_valid && hrsp_tag == TAG_W'(gi);
            dmatrk_entry #(.LINE_W(LINE_W)) u_ent (
                .clk(clk), .rst_n(rst_n),
                .alloc(alloc_vec[gi]), .alloc_wr(sp_wr), .alloc_line(sp_line),
                .rsp_data(hit && hrsp_op == RSP_DATA),
                .rsp_grant(hit && hrsp_op == RSP_GRANT),
                .rsp_cmp(hit && hrsp_op == RSP_CMP),
                .snp_inv(snp_inv_valid && snp_inv_tag == TAG_W'(gi)),
                .wb_go(wb_vec[gi]), .rerfo_go(rerfo_vec[gi]),
                .state(st[gi]), .line(tline[gi]), .lost(tlost[gi])
            );
        end
    endgenerate

    // lowest-numbered idle tracker and line conflict search
    always_comb begin
        free_any = 1'b0;
        free_tag = '0;
        conflict = 1'b0;
        for (int i = NTRK - 1; i >= 0; i--) begin
            if (st[i] == TS_IDLE) begin
                free_any = 1'b1;
                free_tag = TAG_W'(i);
            end else if (tline[i] == sp_line) begin
                conflict = 1'b1;
            end
        end
    end

    // posted-head actions have priority on the home port
    always_comb begin
        head_wb    = pq_head_valid && st[pq_head_tag] == TS_OWNED &&
                     !(snp_inv_valid && snp_inv_tag == pq_head_tag);
        head_rerfo = pq_head_valid && st[pq_head_tag] == TS_OWN_PEND &&
                     tlost[pq_head_tag];
        new_go     = sp_valid && !head_wb && !head_rerfo && free_any && !conflict;
        sp_take    = new_go;
        for (int i = 0; i < NTRK; i++) begin
            alloc_vec[i] = new_go && free_tag == TAG_W'(i);
            wb_vec[i]    = head_wb && pq_head_tag == TAG_W'(i);
            rerfo_vec[i] = head_rerfo && pq_head_tag == TAG_W'(i);
        end
    end

    always_comb begin
        hreq_valid = head_wb || head_rerfo || new_go;
        hreq_op    = OP_RD;
        hreq_tag   = free_tag;
        hreq_line  = sp_line;
        pq_pop     = head_wb;
        if (head_wb || head_rerfo) begin
            hreq_op   = head_wb ? OP_WB : OP_RFO;
            hreq_tag  = pq_head_tag;
            hreq_line = tline[pq_head_tag];
        end else if (new_go) begin
            hreq_op = sp_wr ? OP_RFO : OP_RD;
        end
    end

    AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec)); // R7
    AST_POP_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
        pq_pop |-> (hreq_valid && hreq_op == OP_WB && hreq_tag == pq_head_tag)); // R4
    AST_HEAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_take && pq_head_valid) |-> !(rerfo_vec[pq_head_tag] || wb_vec[pq_head_tag])); // R9
endmodule

// File: tb/tb_dmatrk_seq.sv
`timescale 1ns/1ps
module tb_dmatrk_seq;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_wr = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_lines = '0;
    logic        req_ready;
    logic        hreq_valid;
    logic [1:0]  hreq_op;
    logic [2:0]  hreq_tag;
    logic [25:0] hreq_line;
    logic        hrsp_valid = 1'b0;
    logic [1:0]  hrsp_op = '0;
    logic [2:0]  hrsp_tag = '0;
    logic        snp_inv_valid = 1'b0;
    logic [2:0]  snp_inv_tag = '0;
    logic        pq_head_valid = 1'b0;
    logic [2:0]  pq_head_tag = '0;
    logic        pq_pop;

    always #2.5 clk = ~clk;

    dmatrk_seq dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
        .req_addr(req_addr), .req_lines(req_lines),
        .hreq_valid(hreq_valid), .hreq_op(hreq_op), .hreq_tag(hreq_tag),
        .hreq_line(hreq_line),
        .hrsp_valid(hrsp_valid), .hrsp_op(hrsp_op), .hrsp_tag(hrsp_tag),
        .snp_inv_valid(snp_inv_valid), .snp_inv_tag(snp_inv_tag),
        .pq_head_valid(pq_head_valid), .pq_head_tag(pq_head_tag),
        .pq_pop(pq_pop)
    );

    // bench tracker model: 0 idle, 1 read, 2 own pending, 3 owned, 4 wb pending, 5 lost
    int          mst [N];
    logic [25:0] mline [N];
    logic [25:0] ex_line [256];
    bit          ex_wr [256];
    int          ex_h = 0, ex_t = 0;
    int          pq [64];
    int          pq_h = 0, pq_t = 0;

    int  nchk = 0, nfail = 0, cyc = 0, n_hreq = 0, n_rerfo = 0, max_ownp = 0;
    bit  resp_en = 1, pq_en = 1, rand_pq = 0, done = 0;
    int  snp_mode = 0, spur_op = -1, spur_tag = 0;
    bit  drv_valid = 0, drv_wr = 0;
    logic [31:0] drv_addr = '0;
    logic [3:0]  drv_lines = '0;

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        nchk++;
        if (!cond) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int low_idle();
        for (int i = 0; i < N; i++) if (mst[i] == 0) return i;
        return -1;
    endfunction

    function automatic bit line_busy(input logic [25:0] l);
        for (int i = 0; i < N; i++) if (mst[i] != 0 && mline[i] == l) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int count_st(input int s);
        int c = 0;
        for (int i = 0; i < N; i++) if (mst[i] == s) c++;
        return c;
    endfunction

    function automatic int code(input bit v, input int op, input int tag, input bit pop);
        return (v ? op * 100 + tag : -1) + (pop ? 1000 : 0);
    endfunction

    task automatic cycle();
        int h, lt, off, t, e;
        bit hwb, hre, newe;
        logic [25:0] el;
        bit ew;
        @(negedge clk);
        cyc++;
        hrsp_valid = 0; hrsp_op = 0; hrsp_tag = 0;
        snp_inv_valid = 0; snp_inv_tag = 0;
        if (spur_op >= 0) begin
            hrsp_valid = 1; hrsp_op = 2'(spur_op); hrsp_tag = 3'(spur_tag);
        end else if (resp_en && ($urandom % 3) == 0) begin
            off = int'($urandom % N);
            for (int k = 0; k < N; k++) begin
                t = (off + k) % N;
                if (mst[t] == 1 || mst[t] == 2 || mst[t] == 4) begin
                    hrsp_valid = 1; hrsp_tag = 3'(t);
                    hrsp_op = (mst[t] == 1) ? 2'd0 : (mst[t] == 2) ? 2'd1 : 2'd2;
                    break;
                end
            end
        end
        if (snp_mode == 2 || (snp_mode == 1 && ($urandom % 12) == 0)) begin
            for (int k = 0; k < N; k++) begin
                if (mst[k] == 3) begin
                    snp_inv_valid = 1; snp_inv_tag = 3'(k);
                    break;
                end
            end
        end
        if (rand_pq) pq_en = ($urandom % 4) != 0;
        pq_head_valid = pq_en && (pq_h != pq_t);
        pq_head_tag   = 3'(pq[pq_h % 64]);
        req_valid = drv_valid; req_wr = drv_wr; req_addr = drv_addr; req_lines = drv_lines;
        #1;
        chk(req_ready == (ex_h == ex_t), "R1 ready while lines remain", int'(req_ready), int'(ex_h == ex_t));
        h   = int'(pq_head_tag);
        hwb = pq_head_valid && mst[h] == 3 && !(snp_inv_valid && int'(snp_inv_tag) == h);
        hre = pq_head_valid && mst[h] == 5;
        lt  = low_idle();
        newe = 0; el = '0; ew = 0;
        if (ex_h != ex_t) begin
            el = ex_line[ex_h % 256]; ew = ex_wr[ex_h % 256];
            newe = !hwb && !hre && lt >= 0 && !line_busy(el);
        end
        if (hwb) begin
            e = code(1, 2, h, 1);
            chk(code(hreq_valid, int'(hreq_op), int'(hreq_tag), pq_pop) == e,
                "R4/R9 writeback at posted head", code(hreq_valid, int'(hreq_op), int'(hreq_tag), pq_pop), e);
        end else if (hre) begin
            e = code(1, 1, h, 0);
            chk(code(hreq_valid, int'(hreq_op), int'(hreq_tag), pq_pop) == e,
                "R5 ownership re-request at head", code(hreq_valid, int'(hreq_op), int'(hreq_tag), pq_pop), e);
        end else if (newe) begin
            e = code(1, ew ? 1 : 0, lt, 0);
            chk(code(hreq_valid, int'(hreq_op), int'(hreq_tag), pq_pop) == e,
                ew ? "R3 ownership request for line" : "R2 read request for line",
                code(hreq_valid, int'(hreq_op), int'(hreq_tag), pq_pop), e);
            chk(hreq_line == el, "R1 line address order", int'(hreq_line), int'(el));
        end else begin
            e = code(0, 0, 0, 0);
            chk(code(hreq_valid, int'(hreq_op), int'(hreq_tag), pq_pop) == e,
                (ex_h == ex_t) ? "R1 nothing to issue" : (lt < 0) ? "R7 held without tracker" :
                "R8 held on line conflict", code(hreq_valid, int'(hreq_op), int'(hreq_tag), pq_pop), e);
        end
        if (hreq_valid) n_hreq++;
        // model update for this edge
        if (hrsp_valid && spur_op < 0) begin
            t = int'(hrsp_tag);
            if (mst[t] == 1 && hrsp_op == 2'd0) mst[t] = 0;
            else if (mst[t] == 2 && hrsp_op == 2'd1) mst[t] = 3;
            else if (mst[t] == 4 && hrsp_op == 2'd2) mst[t] = 0;
        end
        spur_op = -1;
        if (snp_inv_valid) mst[int'(snp_inv_tag)] = 5;
        if (hwb) begin
            mst[h] = 4; pq_h++;
        end else if (hre) begin
            mst[h] = 2; n_rerfo++;
        end else if (newe) begin
            mst[lt] = ew ? 2 : 1; mline[lt] = el; ex_h++;
            if (ew) begin pq[pq_t % 64] = lt; pq_t++; end
        end
        if (count_st(2) > max_ownp) max_ownp = count_st(2);
        if (req_valid && req_ready) begin
            for (int j = 0; j < int'(req_lines); j++) begin
                ex_line[ex_t % 256] = req_addr[31:6] + 26'(j);
                ex_wr[ex_t % 256]   = req_wr;
                ex_t++;
            end
            drv_valid = 0;
        end
    endtask

    task automatic send(input bit wr, input logic [31:0] addr, input int lines);
        drv_wr = wr; drv_addr = addr; drv_lines = 4'(lines); drv_valid = 1;
        for (int k = 0; k < 2000 && drv_valid; k++) cycle();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic drain();
        resp_en = 1; pq_en = 1; rand_pq = 0; snp_mode = 0;
        for (int k = 0; k < 3000; k++) begin
            if (ex_h == ex_t && count_st(0) == N) break;
            cycle();
        end
        chk(count_st(0) == N && ex_h == ex_t, "R6 all trackers freed after completions", count_st(0), N);
    endtask

    initial begin
        int base;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin mst[i] = 0; mline[i] = '0; end
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
        chk(hreq_valid == 1'b0 && pq_pop == 1'b0, "R10 quiet home port in reset", int'(hreq_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // tracker exhaustion
        resp_en = 0;
        send(0, 32'h0000_1000, 8);
        send(0, 32'h0000_2000, 1);
        idle(10);
        chk(count_st(0) == 0 && hreq_valid == 1'b0, "R7 pool full holds ninth line", count_st(0), 0);
        drain();

        // conflict plus mismatched responses
        resp_en = 0;
        send(0, 32'h0000_7D3F, 1);
        idle(2);
        spur_op = 2; spur_tag = 0; cycle();
        spur_op = 1; spur_tag = 0; cycle();
        base = n_hreq;
        send(1, 32'h0000_7D00, 1);
        idle(6);
        chk(n_hreq == base, "R11 mismatched responses leave tracker busy", n_hreq - base, 0);
        drain();

        // zero-length request
        send(1, 32'h0000_9000, 0);
        idle(3);
        chk(ex_h == ex_t && count_st(0) == N, "R1 zero-length yields nothing", ex_t - ex_h, 0);

        // pipelined ownership and lost line
        resp_en = 0; pq_en = 0;
        send(1, 32'h0001_0000, 2);
        idle(4);
        chk(count_st(2) == 2, "R3 two ownership requests outstanding", count_st(2), 2);
        resp_en = 1;
        for (int k = 0; k < 500 && count_st(3) < 2; k++) cycle();
        snp_mode = 2; cycle(); snp_mode = 0;
        chk(count_st(5) == 1, "R5 snoop marks line lost", count_st(5), 1);
        base = n_rerfo;
        pq_en = 1;
        drain();
        chk(n_rerfo > base, "R5 lost line re-requested", n_rerfo - base, 1);

        // constrained random phase
        resp_en = 1; snp_mode = 1; rand_pq = 1;
        for (int r = 0; r < 700; r++)
            send(($urandom % 2) == 1, {22'd0, 4'($urandom % 16), 6'($urandom % 64)},
                 int'($urandom % 5));
        drain();
        chk(max_ownp >= 2, "R3 concurrent ownership seen", max_ownp, 2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule